// File: doc/BRIEF.md
# USB endpoint IN reply controller

This block decides how the two transmit endpoints of a USB device answer an IN token from the host. Firmware programs one control byte per endpoint. The byte holds a stall flag, a transmit-enable flag, a data-toggle flag and a byte count. Firmware also fills a small per-endpoint packet buffer through a byte window, and the buffer pointer advances on every write.

On every valid IN token the block registers one reply a cycle later. The reply is STALL, NAK, or a data packet. A data packet carries the DATA0 or DATA1 PID chosen by the toggle flag and the programmed length. The serial engine then reads the packet bytes from the endpoint that was last answered with data. It reports the host's handshake back as either an ACK pulse or a timeout pulse.

An ACK clears the enable of the endpoint that sent the data. A timeout leaves the enable set, so the same packet goes out again on the next IN token. Endpoint 0 also loses its enable when it accepts a SETUP or OUT transaction. Firmware must therefore re-arm an endpoint before every packet.

Top module: `usb_in_reply_ctrl`

## Requirements
- R1: After reset both control bytes read 00h, the buffer select reads 00h and reply_valid is 0.
- R2: An IN token to an endpoint whose stall flag is 0 and enable flag is 0 gives, one cycle later, a one-cycle reply_valid with reply_code 0 (NAK), reply_pid 4'b1010 and reply_len 0.
- R3: An IN token to an endpoint whose stall flag is 1 gives reply_code 1 (STALL), reply_pid 4'b1110 and reply_len 0, whatever the enable flag holds.
- R4: An IN token to an endpoint with stall 0 and enable 1 gives reply_code 2 (DATA) and reply_len equal to the stored count. reply_pid is 4'b0011 (DATA0) when the toggle is 0 and 4'b1011 (DATA1) when it is 1. reply_ep names the endpoint in every reply.
- R5: A host_ack while a data reply is pending clears only the enable of the endpoint that sent the data; its stall, toggle and count are unchanged. A host_timeout leaves the enable set, so the next IN token to that endpoint again gets DATA.
- R6: An ep0_rx_accept pulse clears the enable of endpoint 0 and leaves endpoint 1 unchanged.
- R7: The endpoint 1 count stores only bit 0 of the written count; bits 3:1 read 0. The endpoint 0 count stores the written value clamped to 8.
- R8: Address 0 holds the endpoint 0 control byte and address 1 the endpoint 1 control byte. Both use the layout bit 7 stall, bit 6 enable, bit 5 toggle, bit 4 always 0, bits 3:0 count. reg_rdata shows the addressed byte one cycle after reg_rd.
- R9: A write to address 3 selects the buffer with bit 0 (0 = endpoint 0, 1 = endpoint 1), and bit 1 = 1 resets the pointer to 0. A write to address 2 stores the byte at the pointer and advances the pointer modulo 8. Reading address 3 returns the select in bit 0.
- R10: tx_rd_en with tx_rd_idx returns, on tx_rd_data one cycle later, the buffer byte at that index of the endpoint named by the last DATA reply.
- R11: A host_ack or host_timeout while no data reply is pending has no effect on either control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after reg_rd |
| in_token | input | 1 | Valid IN token pulse |
| in_ep | input | 1 | Endpoint addressed by the token |
| ep0_rx_accept | input | 1 | Endpoint 0 accepted a SETUP or OUT transaction |
| host_ack | input | 1 | Host acknowledged the last data packet |
| host_timeout | input | 1 | No handshake came for the last data packet |
| reply_valid | output | 1 | One-cycle reply strobe |
| reply_code | output | 2 | 0 NAK, 1 STALL, 2 DATA |
| reply_pid | output | 4 | PID of the reply |
| reply_len | output | 4 | Data byte count, 0 unless DATA |
| reply_ep | output | 1 | Endpoint the reply belongs to |
| tx_rd_en | input | 1 | Packet byte read request |
| tx_rd_idx | input | 3 | Byte index within the packet |
| tx_rd_data | output | 8 | Packet byte, one cycle after tx_rd_en |

## Verification
The bench builds the block with its defaults: 8-byte buffers, an endpoint 0 limit of 8 bytes and an endpoint 1 limit of 1 byte. With these values a ninth window write wraps onto index 0 of the buffer. Count values above 8 exercise the clamp, and odd and even counts show endpoint 1 masking. The 3-bit index reaches every buffer byte, so every byte and both length limits are checked in the bench.

// File: rtl/usb_in_reply_pkg.sv
package usb_in_reply_pkg;

  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    RPL_NAK   = 2'd0,
    RPL_STALL = 2'd1,
    RPL_DATA  = 2'd2
  } reply_t;

  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_STALL = 4'b1110;

  typedef struct packed {
    logic             stall;
    logic             en;
    logic             tog;
    logic [CNT_W-1:0] cnt;
  } ep_ctrl_t;

endpackage

// File: rtl/usb_ep_ctrl_reg.sv
module usb_ep_ctrl_reg
  import usb_in_reply_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_MASK = 4'hF,
  parameter logic [CNT_W-1:0] CNT_MAX  = 4'd8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic [6:0] wfield,   // {stall, en, tog, cnt[3:0]}
  input  logic     clr_en,
  output ep_ctrl_t ctrl
);

  logic [CNT_W-1:0] cnt_masked;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_masked = wfield[CNT_W-1:0] & CNT_MASK;
    cnt_next   = (cnt_masked > CNT_MAX) ? CNT_MAX : cnt_masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.stall <= wfield[6];
      ctrl.en    <= wfield[5];
      ctrl.tog   <= wfield[4];
      ctrl.cnt   <= cnt_next;
    end else if (clr_en) begin
      ctrl.en <= 1'b0;
    end
  end

  // R5: a hardware clear drops the enable
  a_r5_clear_drops_enable: assert property (@(posedge clk) disable iff (rst)
    clr_en && !wr_en |=> !ctrl.en);

  // R5: a hardware clear leaves the other fields alone
  a_r5_clear_keeps_fields: assert property (@(posedge clk) disable iff (rst)
    clr_en && !wr_en |=> $stable(ctrl.stall) && $stable(ctrl.tog) && $stable(ctrl.cnt));

  // R7: the stored count never exceeds the endpoint limit
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    ctrl.cnt <= CNT_MAX);

endmodule

// File: rtl/usb_ep_buffer.sv
module usb_ep_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/usb_in_reply_fsm.sv
module usb_in_reply_fsm
  import usb_in_reply_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_token,
  input  logic             in_ep,
  input  ep_ctrl_t         ctrl0,
  input  ep_ctrl_t         ctrl1,
  input  logic             host_ack,
  input  logic             host_timeout,
  output logic             reply_valid,
  output reply_t           reply_code,
  output logic [3:0]       reply_pid,
  output logic [CNT_W-1:0] reply_len,
  output logic             reply_ep,
  output logic             pend_ep,
  output logic [1:0]       ack_clr
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_t;

  st_t              state;
  ep_ctrl_t         sel;
  reply_t           code_d;
  logic [3:0]       pid_d;
  logic [CNT_W-1:0] len_d;

  always_comb begin
    sel = in_ep ? ctrl1 : ctrl0;
    if (sel.stall) begin
      code_d = RPL_STALL;
      pid_d  = PID_STALL;
      len_d  = '0;
    end else if (!sel.en) begin
      code_d = RPL_NAK;
      pid_d  = PID_NAK;
      len_d  = '0;
    end else begin
      code_d = RPL_DATA;
      pid_d  = sel.tog ? PID_DATA1 : PID_DATA0;
      len_d  = sel.cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      reply_valid <= 1'b0;
      reply_code  <= RPL_NAK;
      reply_pid   <= '0;
      reply_len   <= '0;
      reply_ep    <= 1'b0;
      pend_ep     <= 1'b0;
    end else begin
      reply_valid <= in_token;
      if (in_token) begin
        reply_code <= code_d;
        reply_pid  <= pid_d;
        reply_len  <= len_d;
        reply_ep   <= in_ep;
        if (code_d == RPL_DATA) begin
          state   <= ST_WAIT;
          pend_ep <= in_ep;
        end else begin
          state <= ST_IDLE;
        end
      end else if (state == ST_WAIT && (host_ack || host_timeout)) begin
        state <= ST_IDLE;
      end
    end
  end

  always_comb begin
    ack_clr = 2'b00;
    if (state == ST_WAIT && host_ack && !in_token) begin
      ack_clr[pend_ep] = 1'b1;
    end
  end

  // R2: disabled, unstalled endpoint answers NAK one cycle later
  a_r2_nak_reply: assert property (@(posedge clk) disable iff (rst)
    in_token && !sel.stall && !sel.en |=>
      reply_valid && reply_code == RPL_NAK && reply_pid == PID_NAK && reply_len == '0);

  // R3: stall wins over enable
  a_r3_stall_wins: assert property (@(posedge clk) disable iff (rst)
    in_token && sel.stall |=> reply_valid && reply_code == RPL_STALL && reply_pid == PID_STALL);

  // R4: data reply carries toggle-selected PID and the count
  a_r4_data_reply: assert property (@(posedge clk) disable iff (rst)
    in_token && !sel.stall && sel.en |=>
      reply_code == RPL_DATA && reply_len == $past(sel.cnt) &&
      reply_pid == ($past(sel.tog) ? PID_DATA1 : PID_DATA0));

  // R2: the strobe lasts one cycle unless another token follows
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_token |=> !reply_valid);

  // R5: at most one endpoint is cleared per ACK
  a_r5_one_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_clr));

endmodule

// File: rtl/usb_in_reply_ctrl.sv
module usb_in_reply_ctrl
  import usb_in_reply_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BUF_DEPTH   = 8,
  parameter int EP0_MAX_LEN = 8,
  parameter int EP1_MAX_LEN = 1,
  parameter logic [3:0] EP1_CNT_MASK = 4'h1,
  localparam int PTR_W      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_token,
  input  logic              in_ep,
  input  logic              ep0_rx_accept,
  input  logic              host_ack,
  input  logic              host_timeout,
  output logic              reply_valid,
  output logic [1:0]        reply_code,
  output logic [3:0]        reply_pid,
  output logic [3:0]        reply_len,
  output logic              reply_ep,
  input  logic              tx_rd_en,
  input  logic [PTR_W-1:0]  tx_rd_idx,
  output logic [DATA_W-1:0] tx_rd_data
);

  localparam logic [1:0] A_EP0 = 2'd0;
  localparam logic [1:0] A_EP1 = 2'd1;
  localparam logic [1:0] A_WIN = 2'd2;
  localparam logic [1:0] A_BUF = 2'd3;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BUF_DEPTH - 1);

  ep_ctrl_t [1:0]            ctrl_v;
  logic     [1:0]            clr_v;
  logic     [1:0]            ack_clr;
  logic [1:0][DATA_W-1:0]    buf_q;
  logic                      buf_sel;
  logic [PTR_W-1:0]          wr_ptr;
  logic                      pend_ep;
  logic                      rd_ep_q;
  reply_t                    code_q;

  assign clr_v = ack_clr | {1'b0, ep0_rx_accept};

  for (genvar g = 0; g < 2; g++) begin : g_ep
    localparam logic [3:0] CMAX  = (g == 0) ? EP0_MAX_LEN[3:0] : EP1_MAX_LEN[3:0];
    localparam logic [3:0] CMASK = (g == 0) ? 4'hF : EP1_CNT_MASK;

    usb_ep_ctrl_reg #(
      .CNT_MASK (CMASK),
      .CNT_MAX  (CMAX)
    ) i_ctrl (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (reg_wr && reg_addr == 2'(g)),
      .wfield ({reg_wdata[7:5], reg_wdata[3:0]}),
      .clr_en (clr_v[g]),
      .ctrl   (ctrl_v[g])
    );

    usb_ep_buffer #(
      .DATA_W (DATA_W),
      .DEPTH  (BUF_DEPTH)
    ) i_buf (
      .clk     (clk),
      .wr_en   (reg_wr && reg_addr == A_WIN && buf_sel == 1'(g)),
      .wr_addr (wr_ptr),
      .wr_data (reg_wdata),
      .rd_en   (tx_rd_en),
      .rd_addr (tx_rd_idx),
      .rd_data (buf_q[g])
    );
  end

  usb_in_reply_fsm i_fsm (
    .clk          (clk),
    .rst          (rst),
    .in_token     (in_token),
    .in_ep        (in_ep),
    .ctrl0        (ctrl_v[0]),
    .ctrl1        (ctrl_v[1]),
    .host_ack     (host_ack),
    .host_timeout (host_timeout),
    .reply_valid  (reply_valid),
    .reply_code   (code_q),
    .reply_pid    (reply_pid),
    .reply_len    (reply_len),
    .reply_ep     (reply_ep),
    .pend_ep      (pend_ep),
    .ack_clr      (ack_clr)
  );

  assign reply_code = code_q;

  // buffer select and circular pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_sel <= 1'b0;
      wr_ptr  <= '0;
    end else if (reg_wr && reg_addr == A_BUF) begin
      buf_sel <= reg_wdata[0];
      if (reg_wdata[1]) begin
        wr_ptr <= '0;
      end
    end else if (reg_wr && reg_addr == A_WIN) begin
      wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  function automatic logic [DATA_W-1:0] pack_ctrl(input ep_ctrl_t c);
    logic [DATA_W-1:0] b;
    b = '0;
    b[7] = c.stall;
    b[6] = c.en;
    b[5] = c.tog;
    b[3:0] = c.cnt;
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_EP0:   reg_rdata <= pack_ctrl(ctrl_v[0]);
        A_EP1:   reg_rdata <= pack_ctrl(ctrl_v[1]);
        A_BUF:   reg_rdata <= {{(DATA_W-1){1'b0}}, buf_sel};
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ep_q <= 1'b0;
    end else if (tx_rd_en) begin
      rd_ep_q <= pend_ep;
    end
  end

  assign tx_rd_data = buf_q[rd_ep_q];

  // R6: a receive accept on endpoint 0 leaves endpoint 0 disabled
  a_r6_rx_clears_ep0: assert property (@(posedge clk) disable iff (rst)
    ep0_rx_accept && !(reg_wr && reg_addr == A_EP0) |=> !ctrl_v[0].en);

  // R6: a receive accept does not touch endpoint 1
  a_r6_ep1_untouched: assert property (@(posedge clk) disable iff (rst)
    ep0_rx_accept && !host_ack && !(reg_wr && reg_addr == A_EP1) |=> $stable(ctrl_v[1]));

  // R11: handshake with nothing pending changes no control byte
  a_r11_stray_handshake: assert property (@(posedge clk) disable iff (rst)
    ack_clr == 2'b00 && !ep0_rx_accept && !reg_wr |=> $stable(ctrl_v));

endmodule

// File: tb/test_usb_in_reply_ctrl.sv
module test_usb_in_reply_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       in_token, in_ep, ep0_rx_accept, host_ack, host_timeout;
  logic       reply_valid;
  logic [1:0] reply_code;
  logic [3:0] reply_pid, reply_len;
  logic       reply_ep;
  logic       tx_rd_en;
  logic [2:0] tx_rd_idx;
  logic [7:0] tx_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] model [2];
  bit         pend_valid;
  bit         pend_ep_m;

  always #2.5 clk = ~clk;

  usb_in_reply_ctrl i_usb_in_reply_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_token(in_token), .in_ep(in_ep),
    .ep0_rx_accept(ep0_rx_accept), .host_ack(host_ack), .host_timeout(host_timeout),
    .reply_valid(reply_valid), .reply_code(reply_code), .reply_pid(reply_pid),
    .reply_len(reply_len), .reply_ep(reply_ep), .tx_rd_en(tx_rd_en),
    .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stored(input bit ep, input logic [7:0] w);
    logic [3:0] c;
    c = ep ? (w[3:0] & 4'h1) : w[3:0];
    if (!ep && c > 4'd8) c = 4'd8;
    return {w[7:5], 1'b0, c};
  endfunction

  // {code, pid, len}
  function automatic logic [9:0] exp_reply(input logic [7:0] b);
    if (b[7])      return {2'd1, 4'b1110, 4'd0};
    else if (!b[6]) return {2'd0, 4'b1010, 4'd0};
    else           return {2'd2, (b[5] ? 4'b1011 : 4'b0011), b[3:0]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    if (a < 2) model[a[0]] = stored(a[0], d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic token(input bit ep, input string tag);
    logic [9:0] e;
    e = exp_reply(model[ep]);
    in_token = 1'b1; in_ep = ep;
    tick();
    in_token = 1'b0;
    check({tag, " valid"}, reply_valid, 1);
    check({tag, " code/pid/len"}, {reply_code, reply_pid, reply_len}, e);
    check({tag, " ep"}, reply_ep, ep);
    if (e[9:8] == 2'd2) begin pend_valid = 1; pend_ep_m = ep; end
    else pend_valid = 0;
    tick();
    check({tag, " strobe drops"}, reply_valid, 0);
  endtask

  task automatic ack();
    host_ack = 1'b1;
    tick();
    host_ack = 1'b0;
    if (pend_valid) model[pend_ep_m][6] = 1'b0;
    pend_valid = 0;
  endtask

  task automatic tmo();
    host_timeout = 1'b1;
    tick();
    host_timeout = 1'b0;
    pend_valid = 0;
  endtask

  task automatic rxacc();
    ep0_rx_accept = 1'b1;
    tick();
    ep0_rx_accept = 1'b0;
    model[0][6] = 1'b0;
  endtask

  task automatic txrd(input logic [2:0] idx, input logic [7:0] exp, input string tag);
    tx_rd_en = 1'b1; tx_rd_idx = idx;
    tick();
    tx_rd_en = 1'b0;
    check(tag, tx_rd_data, exp);
  endtask

  task automatic cmp_regs(input string tag);
    logic [7:0] d;
    rd(2'd0, d); check({tag, " ep0 byte"}, d, model[0]);
    rd(2'd1, d); check({tag, " ep1 byte"}, d, model[1]);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] bytes [9];
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    in_token = 0; in_ep = 0; ep0_rx_accept = 0; host_ack = 0; host_timeout = 0;
    tx_rd_en = 0; tx_rd_idx = 0;
    model[0] = 0; model[1] = 0; pend_valid = 0; pend_ep_m = 0;
    repeat (3) tick();
    rst = 0;
    tick();

    // R1 reset state
    check("R1 reply_valid", reply_valid, 0);
    rd(2'd0, d); check("R1 ep0 byte", d, 8'h00);
    rd(2'd1, d); check("R1 ep1 byte", d, 8'h00);
    rd(2'd3, d); check("R1 buf select", d, 8'h00);

    // R2 NAK on both endpoints
    token(0, "R2 nak ep0");
    token(1, "R2 nak ep1");

    // R3 stall wins over enable
    wr(2'd1, 8'hE1);
    token(1, "R3 stall+en ep1");
    wr(2'd0, 8'h80);
    token(0, "R3 stall ep0");

    // R7 and R8 count limits and layout
    wr(2'd1, 8'h7F); cmp_regs("R7 ep1 mask");
    check("R7 ep1 count", model[1], 8'h61);
    wr(2'd0, 8'h5F); cmp_regs("R7 ep0 clamp");
    check("R8 bit4 zero ep0", model[0], 8'h48);

    // R9 and R10 buffer fill, wrap and readout
    wr(2'd3, 8'h02);
    rd(2'd3, d); check("R9 select ep0", d, 8'h00);
    for (int i = 0; i < 9; i++) begin
      bytes[i] = 8'($urandom);
      wr(2'd2, bytes[i]);
    end
    wr(2'd0, 8'h48);
    token(0, "R4 data0 len8");
    txrd(3'd0, bytes[8], "R9 wrap index0");
    for (int i = 1; i < 8; i++) txrd(3'(i), bytes[i], "R10 ep0 byte");
    wr(2'd3, 8'h03);
    rd(2'd3, d); check("R9 select ep1", d, 8'h01);
    wr(2'd2, 8'hA5);
    wr(2'd1, 8'h61);
    token(1, "R4 data1 ep1");
    txrd(3'd0, 8'hA5, "R10 ep1 byte");

    // R5 timeout keeps enable, ack clears only enable
    tmo();
    cmp_regs("R5 after timeout");
    token(1, "R5 resend");
    ack();
    cmp_regs("R5 after ack");
    token(1, "R5 nak after ack");

    // R11 stray handshake with nothing pending
    wr(2'd1, 8'h41);
    wr(2'd0, 8'h80);
    token(0, "R11 stall clears pending");
    ack(); tmo();
    cmp_regs("R11 stray");

    // R6 receive accept
    wr(2'd0, 8'h63);
    rxacc();
    cmp_regs("R6 rx accept");
    token(0, "R6 nak after rx");

    // random mix
    for (int it = 0; it < 200; it++) begin
      bit ep;
      int act;
      ep = 1'($urandom);
      if ($urandom_range(0, 2) != 0) wr({1'b0, ep}, 8'($urandom));
      if ($urandom_range(0, 7) == 0) rxacc();
      token(ep, "R4 random reply");
      act = $urandom_range(0, 3);
      if (act == 0) ack();
      else if (act == 1) tmo();
      if (it % 10 == 0) cmp_regs("R5 random regs");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule